// File: doc/BRIEF.md
# Width-Converting FIFO with Endian Select

This block is a single-clock FIFO. Its write port takes long words of twice the read width, and its read port returns half words. Every stored long word is handed out as two consecutive reads. A mode bit, sampled only while master reset is held, selects which half comes out first. In big-endian mode the upper half leads; in little-endian mode the lower half leads.

The read side has two controls for the output bus. The first is a chip-select registered on the clock. The second is an asynchronous output-enable. The bus counts as driven only when both are active. This is modelled as a drive-enable output next to the data, and the data reads as zero whenever the drive-enable is low. Full and empty flags report occupancy in long words. A long-word slot stays occupied until its second half has been read.

Top module: `wconv_fifo`

## Requirements
- R1: Each accepted write stores one long word; the next two accepted reads of that word return its two halves on `rdData`, one clock after each read request is accepted.
- R2: With the mode latched high (big-endian), the first read of a word returns bits [17:9] and the second returns bits [8:0].
- R3: With the mode latched low (little-endian), the first read of a word returns bits [8:0] and the second returns bits [17:9].
- R4: `bigEndSel` is sampled only on clock edges where `rstN` is low; changes while `rstN` is high have no effect on the half order.
- R5: `busDrive` equals `outEn` AND the value `rdCs` had at the last clock edge; `rdData` is zero whenever `busDrive` is low.
- R6: `full` is high exactly when DEPTH long words are stored.
- R7: `empty` is high only when no long word is stored and no half of a partly read word remains.
- R8: A read request while `empty` is high is ignored: the flags, the pointers, the half state and the registered read data are unchanged.
- R9: A write request while `full` is high is ignored, and the word offered is never read out.
- R10: Master reset (`rstN` low at a clock edge) empties the FIFO. After it, `empty` is 1, `full` is 0, `busDrive` is 0 and the half state restarts at the first half.
- R11: A slot is freed only after its second half is read: reading one half of a word from a full FIFO leaves `full` high.
- R12: A read and a write in the same cycle are both accepted when the flags at that edge allow each of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rstN | input | 1 | Synchronous master reset, active low |
| bigEndSel | input | 1 | Half-order mode, sampled during master reset (1 = upper half first) |
| wrEn | input | 1 | Write request |
| wrData | input | 18 | Long word to store |
| rdEn | input | 1 | Read request for one half word |
| rdCs | input | 1 | Read chip-select, registered on the clock |
| outEn | input | 1 | Asynchronous output enable |
| rdData | output | 9 | Half word out, zero when not driven |
| busDrive | output | 1 | High when the output bus is driven |
| full | output | 1 | All long-word slots occupied |
| empty | output | 1 | Nothing left to read |

## Verification
The assertions check properties on every cycle. The long-word count never exceeds DEPTH. A rejected read or write leaves the pointers and the half state unchanged. Reading a first half never moves the read pointer. The mode bit cannot change outside reset. A driven bus always traces back to a chip-select that was active at the previous edge. Only the bench's reference model can show that the right half comes out in the right order for each mode and data pattern. It also shows that words offered while full never appear, and that simultaneous reads and writes keep the data stream intact.

// File: rtl/wconv_pkg.sv
package wconv_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic wrStrobe;   // store wrData at wrAddr
    logic rdStrobe;   // load one half from rdAddr into the output register
    logic pickUpper;  // which half of the long word to load
  } strobe_t;
endpackage

// File: rtl/wconv_ctrl.sv
module wconv_ctrl
  import wconv_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       bigEndSel,
  input  logic                       wrEn,
  input  logic                       rdEn,
  output strobe_t                    strb,
  output logic [$clog2(DEPTH)-1:0]   wrAddr,
  output logic [$clog2(DEPTH)-1:0]   rdAddr,
  output logic                       full,
  output logic                       empty
);
  localparam int AW    = $clog2(DEPTH);
  localparam int PTR_W = AW + 1;

  logic [PTR_W-1:0] wrPtrQ, rdPtrQ, count;
  logic             halfQ;   // 0: next read is the first half of the head word
  logic             bigQ;

  assign count = wrPtrQ - rdPtrQ;
  assign full  = (count == PTR_W'(DEPTH));
  assign empty = (count == '0);

  assign strb.wrStrobe  = wrEn && !full;
  assign strb.rdStrobe  = rdEn && !empty;
  assign strb.pickUpper = bigQ ^ halfQ;

  assign wrAddr = wrPtrQ[AW-1:0];
  assign rdAddr = rdPtrQ[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtrQ <= '0;
      rdPtrQ <= '0;
      halfQ  <= 1'b0;
      bigQ   <= bigEndSel;
    end else begin
      if (strb.wrStrobe) wrPtrQ <= wrPtrQ + 1'b1;
      if (strb.rdStrobe) begin
        if (halfQ) begin
          rdPtrQ <= rdPtrQ + 1'b1;
          halfQ  <= 1'b0;
        end else begin
          halfQ  <= 1'b1;
        end
      end
    end
  end

  // R6: occupancy never passes the array depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    count <= PTR_W'(DEPTH));
  // R7: a partly read word keeps the FIFO non-empty
  p_empty_clean_r7: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !halfQ);
  // R8: read while empty leaves read state alone
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (empty && rdEn) |=> ($stable(rdPtrQ) && $stable(halfQ)));
  // R9: write while full leaves write pointer alone
  p_full_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (full && wrEn) |=> $stable(wrPtrQ));
  // R11: first-half read never frees the slot
  p_slot_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!halfQ && rdEn) |=> $stable(rdPtrQ));
  // R4: mode is fixed outside reset
  p_mode_fixed_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(bigQ));
endmodule

// File: rtl/wconv_dpath.sv
module wconv_dpath
  import wconv_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int HALF_W = 9
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  logic [$clog2(DEPTH)-1:0]   wrAddr,
  input  logic [$clog2(DEPTH)-1:0]   rdAddr,
  input  logic [2*HALF_W-1:0]        wrData,
  input  logic                       rdCs,
  input  logic                       outEn,
  output logic [HALF_W-1:0]          rdData,
  output logic                       busDrive
);
  localparam int LONG_W = 2 * HALF_W;

  logic [LONG_W-1:0] mem [DEPTH];
  logic [HALF_W-1:0] rdDataQ;
  logic              csQ;

  always_ff @(posedge clk) begin
    if (strb.wrStrobe) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataQ <= '0;
      csQ     <= 1'b0;
    end else begin
      csQ <= rdCs;
      if (strb.rdStrobe)
        rdDataQ <= strb.pickUpper ? mem[rdAddr][LONG_W-1:HALF_W]
                                  : mem[rdAddr][HALF_W-1:0];
    end
  end

  assign busDrive = outEn && csQ;
  assign rdData   = busDrive ? rdDataQ : '0;

  // R5: a driven bus needs chip-select at the previous edge
  p_cs_sync_r5: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> $past(rdCs));
  // R5: an undriven bus shows zero
  p_quiet_bus_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busDrive |-> (rdData == '0));
endmodule

// File: rtl/wconv_fifo.sv
module wconv_fifo
  import wconv_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int HALF_W = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bigEndSel,
  input  logic                wrEn,
  input  logic [2*HALF_W-1:0] wrData,
  input  logic                rdEn,
  input  logic                rdCs,
  input  logic                outEn,
  output logic [HALF_W-1:0]   rdData,
  output logic                busDrive,
  output logic                full,
  output logic                empty
);
  localparam int AW = $clog2(DEPTH);

  strobe_t         strb;
  logic [AW-1:0]   wrAddr, rdAddr;

  wconv_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .bigEndSel(bigEndSel),
    .wrEn(wrEn), .rdEn(rdEn), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .full(full), .empty(empty)
  );

  wconv_dpath #(.DEPTH(DEPTH), .HALF_W(HALF_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdCs(rdCs), .outEn(outEn),
    .rdData(rdData), .busDrive(busDrive)
  );
endmodule

// File: tb/tb_wconv_fifo.sv
module tb_wconv_fifo;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0, bigEndSel = 1'b1;
  logic        wrEn = 1'b0, rdEn = 1'b0, rdCs = 1'b0, outEn = 1'b0;
  logic [17:0] wrData = '0;
  logic [8:0]  rdData;
  logic        busDrive, full, empty;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [17:0] mq[$];
  bit          mHalf = 0, mBig = 1, mCs = 0;
  logic [8:0]  mData = '0;

  always #2 clk = ~clk;

  wconv_fifo #(.DEPTH(DEPTH), .HALF_W(9)) dut (
    .clk(clk), .rstN(rstN), .bigEndSel(bigEndSel), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdCs(rdCs), .outEn(outEn),
    .rdData(rdData), .busDrive(busDrive), .full(full), .empty(empty)
  );

  task automatic step(input bit rst, input bit be, input bit wr,
                      input logic [17:0] wd, input bit rd, input bit cs,
                      input bit oe, input string tag);
    bit doRd, doWr, upper, eFull, eEmpty, eDrive;
    logic [8:0] eData;
    @(negedge clk);
    rstN = ~rst; bigEndSel = be; wrEn = wr; wrData = wd;
    rdEn = rd; rdCs = cs; outEn = oe;
    @(posedge clk);
    if (rst) begin
      mq.delete(); mHalf = 0; mBig = be; mCs = 0; mData = '0;
    end else begin
      doRd = rd && (mq.size() > 0);
      doWr = wr && (mq.size() < DEPTH);
      if (doRd) begin
        upper = mBig ? (mHalf == 0) : (mHalf == 1);
        mData = upper ? mq[0][17:9] : mq[0][8:0];
        if (mHalf) begin
          void'(mq.pop_front());
          mHalf = 0;
        end else mHalf = 1;
      end
      if (doWr) mq.push_back(wd);
      mCs = cs;
    end
    #1;
    eFull  = (mq.size() == DEPTH);
    eEmpty = (mq.size() == 0);
    eDrive = oe && mCs;
    eData  = eDrive ? mData : 9'd0;
    checks++;
    if (full !== eFull || empty !== eEmpty || busDrive !== eDrive || rdData !== eData) begin
      fails++;
      $display("FAIL %s: got full=%0b empty=%0b drive=%0b data=%h, expected full=%0b empty=%0b drive=%0b data=%h",
               tag, full, empty, busDrive, rdData, eFull, eEmpty, eDrive, eData);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R10: reset state, big-endian latched
    step(1, 1, 0, 0, 0, 1, 1, "R10");
    step(1, 1, 0, 0, 0, 1, 1, "R10");
    step(0, 1, 0, 0, 0, 1, 1, "R10");
    // R8: read when empty ignored
    step(0, 1, 0, 0, 1, 1, 1, "R8");
    // R4: mode input moves after reset, must not matter
    step(0, 0, 1, 18'h2A5C3, 0, 1, 1, "R1");
    step(0, 0, 1, 18'h15A3C, 0, 1, 1, "R1");
    // R2: big-endian order, R7 partial word keeps non-empty
    step(0, 0, 0, 0, 1, 1, 1, "R2");
    step(0, 0, 0, 0, 1, 1, 1, "R2");
    step(0, 1, 0, 0, 1, 1, 1, "R4");
    step(0, 1, 0, 0, 0, 1, 1, "R7");
    step(0, 0, 0, 0, 1, 1, 1, "R7");
    step(0, 0, 0, 0, 1, 1, 1, "R8");
    // R6: fill to DEPTH, R9: extra writes dropped
    for (int i = 0; i < DEPTH; i++)
      step(0, 0, 1, 18'h01000 + 18'(i * 18'h0404B), 0, 1, 1, "R6");
    step(0, 0, 1, 18'h3FFFF, 0, 1, 1, "R9");
    step(0, 0, 1, 18'h3FFFE, 0, 1, 1, "R9");
    // R11: first-half read keeps full; write rejected in the same cycle
    step(0, 0, 1, 18'h3FFFD, 1, 1, 1, "R11");
    // R12: second-half read with write: write sees full, so rejected
    step(0, 0, 1, 18'h3FFFC, 1, 1, 1, "R12");
    // R12: now not full, read and write together accepted
    step(0, 0, 1, 18'h2BEEF, 1, 1, 1, "R12");
    step(0, 0, 1, 18'h1CAFE, 1, 1, 1, "R12");
    // R5: gating combinations while reading
    step(0, 0, 0, 0, 1, 0, 1, "R5");
    step(0, 0, 0, 0, 1, 1, 0, "R5");
    step(0, 0, 0, 0, 0, 1, 1, "R5");
    step(0, 0, 0, 0, 0, 0, 1, "R5");
    step(0, 0, 0, 0, 0, 1, 0, "R5");
    // drain, checking R9 words never appear
    for (int i = 0; i < 2 * DEPTH + 2; i++)
      step(0, 0, 0, 0, 1, 1, 1, "R9");
    // R10 again, now latch little-endian with data stored first
    step(0, 0, 1, 18'h12345, 0, 1, 1, "R10");
    step(1, 0, 1, 18'h12345, 1, 1, 1, "R10");
    step(0, 1, 0, 0, 0, 1, 1, "R10");
    // R3: little-endian order, mode input held high
    step(0, 1, 1, 18'h3C1A5, 0, 1, 1, "R3");
    step(0, 1, 1, 18'h00E1F, 1, 1, 1, "R3");
    step(0, 1, 0, 0, 1, 1, 1, "R3");
    step(0, 1, 0, 0, 1, 1, 1, "R3");
    step(0, 1, 0, 0, 1, 1, 1, "R4");
    step(0, 1, 0, 0, 1, 1, 1, "R8");
    // R10: reset mid-word clears the partial half
    step(0, 1, 1, 18'h2D2D2, 0, 1, 1, "R1");
    step(0, 1, 0, 0, 1, 1, 1, "R1");
    step(1, 1, 0, 0, 0, 1, 1, "R10");
    step(0, 1, 1, 18'h19876, 0, 1, 1, "R10");
    step(0, 1, 0, 0, 1, 1, 1, "R2");
    step(0, 1, 0, 0, 1, 1, 1, "R2");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule